// File: doc/BRIEF.md
# Saturating Reliability-Vector Update Unit

This block keeps the soft state of one variable node in an iterative majority-logic decoder for codes over a finite field with 32 elements. The state is a vector of 32 small unsigned reliability counters and the current hard-decision symbol. Each check-node message arrives as one field element `sigma`, and it votes for the counter at that index.

Counters saturate at `RMAX = 2^CNT_W - 1`, which is 7 by default. A vote for a counter that is below the ceiling raises it by one. A vote for a counter that is already at the ceiling leaves it there and takes one away from every other nonzero counter. Only that second kind of vote can move the hard decision, which becomes `sigma`. The hard decision therefore always points at a counter holding the ceiling, and no search for the largest counter is needed at the end of an iteration.

A load port starts a new codeword from a received hard decision. A strobed update port applies one vote per cycle. Both results appear on the outputs in the cycle after the strobe.

Top module: `relvec_update_unit`

## Requirements
- R1: After synchronous reset, `hard_sym` is 0, counter 0 holds 7 and all other counters hold 0.
- R2: When `load_valid` is high, the next cycle shows counter `load_sym` at 7, every other counter at 0 and `hard_sym` equal to `load_sym`. A load takes priority over an update strobed in the same cycle.
- R3: An update whose selected counter (index `upd_sym`) is below 7 raises that counter by one and leaves all other counters and `hard_sym` unchanged.
- R4: An update whose selected counter is already 7 keeps it at 7, lowers every other nonzero counter by one and leaves zero counters at 0.
- R5: `hard_sym` takes the value `upd_sym` only on an update whose selected counter was already 7. Otherwise it keeps its value unless a load occurs.
- R6: In a cycle with neither `load_valid` nor `upd_valid` high, all counters and `hard_sym` keep their values.
- R7: The counter at index `hard_sym` always reads 7.
- R8: Counter i is presented on `rel_vec[i*3 +: 3]`.
- R9: The effect of a load or an update is visible on the outputs exactly one clock after the cycle in which it is strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_valid | input | 1 | Start a new codeword from `load_sym` |
| load_sym | input | 5 | Received hard-decision symbol |
| upd_valid | input | 1 | Apply one check-node vote |
| upd_sym | input | 5 | Field element `sigma` of the vote |
| hard_sym | output | 5 | Current hard-decision symbol |
| rel_vec | output | 96 | Packed counter vector, 3 bits per counter |

## Verification
A wrong counter that the outputs expose appears on `rel_vec` in the very next cycle. A wrong saturation decision does more damage. It can hold the selected counter when it should have risen, or decrement neighbours that should have been left alone. It also shows up within a cycle as either a `hard_sym` that fails to follow `sigma` or a `hard_sym` that no longer points at a counter of 7. Long biased vote streams drive many symbols to the ceiling and make the hard decision flip several times between loads, so a decrement or floor error accumulates into a visible mismatch against the bench model.

// File: rtl/relvec_pkg.sv
package relvec_pkg;

    localparam int unsigned CNT_W   = 3;
    localparam int unsigned NUM_SYM = 32;

    // Operation applied to the whole vector in one cycle
    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_LOAD = 2'd1,
        OP_STEP = 2'd2,
        OP_CLIP = 2'd3
    } vec_op_e;

    function automatic vec_op_e pick_op(input logic ld, input logic up, input logic at_top);
        if (ld)
            return OP_LOAD;
        else if (up)
            return at_top ? OP_CLIP : OP_STEP;
        else
            return OP_IDLE;
    endfunction

endpackage

// File: rtl/sym_onehot_dec.sv
module sym_onehot_dec #(
    parameter int unsigned NSYM = 32,
    localparam int unsigned SW  = $clog2(NSYM)
) (
    input  logic [SW-1:0]   sym,
    output logic [NSYM-1:0] onehot
);
    for (genvar i = 0; i < NSYM; i++) begin : g_bit
        assign onehot[i] = (sym == SW'(i));
    end
endmodule

// File: rtl/rel_cell.sv
module rel_cell
    import relvec_pkg::*;
#(
    parameter int unsigned CW      = 3,
    parameter bit          RST_TOP = 1'b0,
    localparam logic [CW-1:0] RMAX = {CW{1'b1}}
) (
    input  logic          clk,
    input  logic          rst,
    input  vec_op_e       op,
    input  logic          sel,
    input  logic          hit,
    output logic [CW-1:0] cnt_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= RST_TOP ? RMAX : '0;
        end else begin
            unique case (op)
                OP_LOAD: cnt_q <= hit ? RMAX : '0;
                OP_STEP: if (sel) cnt_q <= cnt_q + CW'(1);
                OP_CLIP: if (!sel && cnt_q != '0) cnt_q <= cnt_q - CW'(1);
                default: ;
            endcase
        end
    end

    assert_step_R3: assert property (@(posedge clk) disable iff (rst)
        (op == OP_STEP && sel) |=> (cnt_q == $past(cnt_q) + CW'(1)));
    assert_step_other_R3: assert property (@(posedge clk) disable iff (rst)
        (op == OP_STEP && !sel) |=> $stable(cnt_q));
    assert_clip_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (op == OP_CLIP && sel) |=> (cnt_q == RMAX));
    assert_clip_decr_R4: assert property (@(posedge clk) disable iff (rst)
        (op == OP_CLIP && !sel && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CW'(1)));
    assert_floor_R4: assert property (@(posedge clk) disable iff (rst)
        (op == OP_CLIP && cnt_q == '0) |=> (cnt_q == '0));
    assert_idle_R6: assert property (@(posedge clk) disable iff (rst)
        (op == OP_IDLE) |=> $stable(cnt_q));
endmodule

// File: rtl/relvec_update_unit.sv
module relvec_update_unit
    import relvec_pkg::*;
#(
    parameter int unsigned NSYM = relvec_pkg::NUM_SYM,
    parameter int unsigned CW   = relvec_pkg::CNT_W,
    localparam int unsigned SW  = $clog2(NSYM),
    localparam logic [CW-1:0] RMAX = {CW{1'b1}}
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load_valid,
    input  logic [SW-1:0]      load_sym,
    input  logic               upd_valid,
    input  logic [SW-1:0]      upd_sym,
    output logic [SW-1:0]      hard_sym,
    output logic [NSYM*CW-1:0] rel_vec
);
    logic [NSYM-1:0] upd_oh;
    logic [NSYM-1:0] load_oh;
    logic [CW-1:0]   cnt [NSYM];
    logic            at_top;
    vec_op_e         op;
    logic [SW-1:0]   hard_q;

    sym_onehot_dec #(.NSYM(NSYM)) u_upd_dec  (.sym(upd_sym),  .onehot(upd_oh));
    sym_onehot_dec #(.NSYM(NSYM)) u_load_dec (.sym(load_sym), .onehot(load_oh));

    // Selected counter already at the ceiling
    assign at_top = (cnt[upd_sym] == RMAX);
    assign op     = pick_op(load_valid, upd_valid, at_top);

    for (genvar i = 0; i < NSYM; i++) begin : g_cell
        rel_cell #(.CW(CW), .RST_TOP(i == 0)) u_cell (
            .clk   (clk),
            .rst   (rst),
            .op    (op),
            .sel   (upd_oh[i]),
            .hit   (load_oh[i]),
            .cnt_q (cnt[i])
        );
        assign rel_vec[i*CW +: CW] = cnt[i];
    end

    always_ff @(posedge clk) begin
        if (rst)
            hard_q <= '0;
        else if (op == OP_LOAD)
            hard_q <= load_sym;
        else if (op == OP_CLIP)
            hard_q <= upd_sym;
    end

    assign hard_sym = hard_q;

    assert_hard_top_R7: assert property (@(posedge clk) disable iff (rst)
        cnt[hard_q] == RMAX);
    assert_hard_swap_R5: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && !load_valid && at_top) |=> (hard_q == $past(upd_sym)));
    assert_hard_keep_R5: assert property (@(posedge clk) disable iff (rst)
        (!load_valid && !(upd_valid && at_top)) |=> $stable(hard_q));
    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        load_valid |=> (hard_q == $past(load_sym)));
endmodule

// File: tb/relvec_update_unit_tb.sv
module relvec_update_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 32;
    localparam int CW = 3;
    localparam int RM = 7;

    logic clk = 1'b0;
    logic rst;
    logic load_valid, upd_valid;
    logic [4:0] load_sym, upd_sym;
    logic [4:0] hard_sym;
    logic [NS*CW-1:0] rel_vec;

    int total = 0;
    int bad = 0;
    bit done = 0;

    int mdl [NS];
    int mhard;

    logic [4:0]       q_hard [$];
    logic [NS*CW-1:0] q_vec  [$];
    string            q_tag  [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    relvec_update_unit dut_i (
        .clk(clk), .rst(rst),
        .load_valid(load_valid), .load_sym(load_sym),
        .upd_valid(upd_valid), .upd_sym(upd_sym),
        .hard_sym(hard_sym), .rel_vec(rel_vec)
    );

    function automatic logic [NS*CW-1:0] pack_model();
        logic [NS*CW-1:0] v;
        for (int i = 0; i < NS; i++) v[i*CW +: CW] = CW'(mdl[i]); // R8 packing
        return v;
    endfunction

    task automatic check_state(input logic [4:0] eh, input logic [NS*CW-1:0] ev, input string tag);
        total++;
        if (hard_sym !== eh) begin
            bad++;
            $display("FAIL %s hard_sym actual=%0d expected=%0d", tag, hard_sym, eh);
        end
        total++;
        if (rel_vec !== ev) begin
            bad++;
            $display("FAIL %s rel_vec actual=%h expected=%h", tag, rel_vec, ev);
        end
        total++;
        if (rel_vec[hard_sym*CW +: CW] !== 3'(RM)) begin
            bad++;
            $display("FAIL R7 counter at hard index actual=%0d expected=%0d",
                     rel_vec[hard_sym*CW +: CW], RM);
        end
    endtask

    // Driver: drive at negedge, update model, push expected (R9: checked one edge later)
    task automatic do_op(input bit ld, input int ls, input bit up, input int us, input string tag);
        @(negedge clk);
        load_valid = ld; load_sym = 5'(ls);
        upd_valid  = up; upd_sym  = 5'(us);
        if (ld) begin
            for (int i = 0; i < NS; i++) mdl[i] = 0;
            mdl[ls] = RM;
            mhard = ls;
        end else if (up) begin
            if (mdl[us] == RM) begin
                for (int i = 0; i < NS; i++)
                    if (i != us && mdl[i] > 0) mdl[i]--;
                mhard = us;
            end else begin
                mdl[us]++;
            end
        end
        q_hard.push_back(5'(mhard));
        q_vec.push_back(pack_model());
        q_tag.push_back(tag);
    endtask

    // Monitor: compare the state produced by the previous strobe
    always @(posedge clk) begin
        #1;
        if (q_hard.size() > 0) begin
            logic [4:0] eh;
            logic [NS*CW-1:0] ev;
            string tg;
            eh = q_hard.pop_front();
            ev = q_vec.pop_front();
            tg = q_tag.pop_front();
            check_state(eh, ev, tg);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        rst = 1'b1; load_valid = 0; upd_valid = 0; load_sym = 0; upd_sym = 0;
        for (int i = 0; i < NS; i++) mdl[i] = 0;
        mdl[0] = RM; mhard = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check_state(5'd0, pack_model(), "R1 reset");

        do_op(1, 5, 0, 0, "R2 load");
        do_op(0, 0, 1, 3, "R3 step");
        do_op(0, 0, 1, 3, "R3 step");
        do_op(0, 0, 1, 3, "R3 step");
        do_op(0, 0, 0, 0, "R6 idle");
        do_op(0, 0, 1, 5, "R4 clip at hard symbol");
        do_op(0, 0, 1, 12, "R3 step other");
        for (int k = 0; k < 6; k++) do_op(0, 0, 1, 9, "R3 climb");
        do_op(0, 0, 1, 9, "R3 reach ceiling");
        do_op(0, 0, 1, 9, "R5 swap on clip");
        do_op(0, 0, 1, 9, "R4 floor at zero");
        do_op(0, 0, 0, 7, "R6 ignored sigma without strobe");
        do_op(1, 31, 1, 9, "R2 load wins over update");
        do_op(0, 0, 1, 31, "R4 clip with all others zero");

        lfsr = 16'hACE1;
        for (int k = 0; k < 600; k++) begin
            int s;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            s = lfsr[7] ? int'(lfsr[4:0]) : int'(lfsr[1:0]);
            if (lfsr[15:11] == 5'd0)
                do_op(1, int'(lfsr[9:5]), lfsr[3], s, "R2 random load");
            else if (lfsr[10:8] == 3'd0)
                do_op(0, 0, 0, s, "R6 random idle");
            else
                do_op(0, 0, 1, s, "R5 random vote");
        end

        @(negedge clk);
        load_valid = 0; upd_valid = 0;
        @(posedge clk); #2;
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule